// File: doc/BRIEF.md
# Serial Slave Sample Readout Port

This block is the serial readout side of a converter's digital interface. Each time the converter signals that a conversion has finished, the block captures the new sample into an output shift register. An external host then pulls the sample out one bit per rising edge of its own serial clock. The host holds both the active-low chip select and the active-low read strobe low while it does this, and it receives the most significant bit first.

The external serial clock is brought into the system clock domain through a synchronizer, and only its rising edges are used. The clock is ignored unless chip select and read are both low. A framing output marks the span during which serial data is valid. A configuration input chooses whether that span is shown as a high level or as a low level.

If a fresh result arrives while a read is part-way through, the unread bits are dropped. The new sample takes their place, and an error output pulses for one system clock. The next read then starts again at the most significant bit of the new sample.

Top module: `ser_result_port`

## Requirements
- R1: While chip select or read is high, the serial data output is 0 and the framing output sits at its idle level (idle level equals the polarity input).
- R2: A rising edge of the external serial clock shifts out a bit only while chip select and read are both low. With either one high, edges are ignored and no bits are lost.
- R3: With the polarity input at 0, the framing output is 1 while serial data is valid and 0 otherwise.
- R4: With the polarity input at 1, the framing output is 0 while serial data is valid and 1 otherwise.
- R5: A conversion-done pulse latches the SAMPLE_W-bit input sample. A read presents the sample most significant bit first, and each accepted serial-clock rising edge advances it by one bit.
- R6: Once all SAMPLE_W bits have been shifted, the data output stays 0 and the framing output returns to idle, whatever further clock edges arrive.
- R7: A conversion-done pulse that arrives after 1 to SAMPLE_W-1 bits of the current sample have shifted raises the error output for exactly one system clock, in the cycle after the pulse. In every other case the error output stays 0.
- R8: When a conversion-done pulse and an accepted serial-clock edge fall in the same system clock cycle, the load wins. The edge shifts nothing, and the next read starts at the new sample's most significant bit.
- R9: After reset, no sample is pending, the data output is 0, the framing output is idle and the error output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_done | input | 1 | One-cycle pulse: a conversion result is ready |
| conv_data | input | SAMPLE_W | Converted sample, valid with conv_done |
| cs_n | input | 1 | Active-low chip select, also gates the serial clock |
| rd_n | input | 1 | Active-low read strobe |
| sclk_ext | input | 1 | External serial clock, asynchronous, rising edge active |
| frame_inv | input | 1 | Framing polarity select: 0 = active high, 1 = active low |
| sdo | output | 1 | Serial data out, MSB first |
| frame | output | 1 | Framing indicator for valid serial data |
| rd_err | output | 1 | One-cycle pulse: an unfinished read was overwritten |

## Verification
Two functions can land in the same system clock cycle: loading a new sample and shifting on a synchronized serial-clock edge. The bench raises the serial clock and times a conversion-done pulse so that the load coincides with the cycle in which the synchronized edge would shift. It then expects the error pulse, because a read was part-way through, and it expects the following read to return all bits of the new sample from its MSB. If the shift had won, or the two had merged, that read would come out missing or misaligned, and the scoreboard would report it.

// File: rtl/ser_port_pkg.sv
package ser_port_pkg;
    localparam int DEF_SAMPLE_W   = 18;
    localparam int DEF_SYNC_STAGE = 2;

    // Registered state of the top-level glue
    typedef struct packed {
        logic rd_open;
    } glue_st_t;
endpackage

// File: rtl/srp_sclk_sync.sv
module srp_sclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_async,
    output logic sclk_rise
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[DEPTH-2:0], sclk_async};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sclk_rise = sync_q[STAGES-1] & ~sync_q[STAGES];

    // a detected rise cannot repeat on the next cycle
    p_rise_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise |=> !sclk_rise);
endmodule

// File: rtl/srp_shifter.sv
module srp_shifter #(
    parameter int SAMPLE_W = 18
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [SAMPLE_W-1:0] load_data,
    input  logic                step,
    input  logic                rd_open,
    output logic                bit_out,
    output logic                bits_valid,
    output logic                err_pulse
);
    localparam int CNT_W = $clog2(SAMPLE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(SAMPLE_W);

    typedef struct packed {
        logic [SAMPLE_W-1:0] sreg;
        logic [CNT_W-1:0]    left;
        logic                err;
    } shf_st_t;

    shf_st_t st_d, st_q;
    logic    in_progress;

    always_comb begin
        st_d        = st_q;
        st_d.err    = 1'b0;
        in_progress = (st_q.left != '0) && (st_q.left != FULL);
        if (load) begin
            st_d.sreg = load_data;
            st_d.left = FULL;
            st_d.err  = in_progress;
        end else if (step && rd_open && st_q.left != '0) begin
            st_d.sreg = {st_q.sreg[SAMPLE_W-2:0], 1'b0};
            st_d.left = st_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_out    = st_q.sreg[SAMPLE_W-1];
    assign bits_valid = st_q.left != '0;
    assign err_pulse  = st_q.err;

    p_no_shift_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_open && !load) |=> $stable(st_q.left) && $stable(st_q.sreg));
    p_load_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st_q.left == FULL) && (st_q.sreg == $past(load_data)));
    p_count_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.left <= FULL);
    p_err_needs_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(load));
endmodule

// File: rtl/ser_result_port.sv
module ser_result_port
    import ser_port_pkg::*;
#(
    parameter int SAMPLE_W   = DEF_SAMPLE_W,
    parameter int SYNC_STAGE = DEF_SYNC_STAGE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                conv_done,
    input  logic [SAMPLE_W-1:0] conv_data,
    input  logic                cs_n,
    input  logic                rd_n,
    input  logic                sclk_ext,
    input  logic                frame_inv,
    output logic                sdo,
    output logic                frame,
    output logic                rd_err
);
    glue_st_t g_d, g_q;
    logic     sclk_rise;
    logic     bit_out;
    logic     bits_valid;
    logic     data_live;

    always_comb begin
        g_d         = g_q;
        g_d.rd_open = ~cs_n & ~rd_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    srp_sclk_sync #(.STAGES(SYNC_STAGE)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_async (sclk_ext),
        .sclk_rise  (sclk_rise)
    );

    srp_shifter #(.SAMPLE_W(SAMPLE_W)) u_shf (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (conv_done),
        .load_data  (conv_data),
        .step       (sclk_rise),
        .rd_open    (g_q.rd_open),
        .bit_out    (bit_out),
        .bits_valid (bits_valid),
        .err_pulse  (rd_err)
    );

    assign data_live = g_q.rd_open & bits_valid;
    assign sdo       = data_live & bit_out;
    assign frame     = data_live ^ frame_inv;

    p_idle_closed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n) || $past(rd_n)) |-> (!sdo && (frame == frame_inv)));
    p_err_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |=> !rd_err);
endmodule

// File: tb/ser_result_port_bench.sv
module ser_result_port_bench;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         conv_done = 1'b0;
    logic [W-1:0] conv_data = '0;
    logic         cs_n = 1'b1;
    logic         rd_n = 1'b1;
    logic         sclk_ext = 1'b0;
    logic         frame_inv = 1'b0;
    logic         sdo, frame, rd_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic exp_q[$];

    always #4 clk = ~clk;

    ser_result_port #(.SAMPLE_W(W)) u_ser_result_port (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
        .cs_n(cs_n), .rd_n(rd_n), .sclk_ext(sclk_ext), .frame_inv(frame_inv),
        .sdo(sdo), .frame(frame), .rd_err(rd_err)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // driver: load a sample and push its expected bit stream
    task automatic load(input logic [W-1:0] d);
        @(negedge clk);
        conv_data = d;
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        exp_q.delete();
        for (int i = W - 1; i >= 0; i--) exp_q.push_back(d[i]);
    endtask

    task automatic sck_pulse();
        sclk_ext = 1'b1;
        repeat (4) @(negedge clk);
        sclk_ext = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic open_rd();
        cs_n = 1'b0; rd_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic close_rd();
        cs_n = 1'b1; rd_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // monitor: pop expected bits and compare against the serial output
    task automatic read_bits(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            logic e;
            e = exp_q.pop_front();
            chk(req, sdo, e);
            chk(req, frame, ~frame_inv);
            sck_pulse();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 sdo", sdo, 1'b0);
        chk("R9 frame", frame, 1'b0);
        chk("R9 rd_err", rd_err, 1'b0);

        // full read, active-high framing
        load(18'h2A5C3);
        chk("R7 no err on fresh load", rd_err, 1'b0);
        open_rd();
        read_bits(W, "R5 R3");
        chk("R6 sdo idle", sdo, 1'b0);
        chk("R3 frame idle", frame, 1'b0);
        sck_pulse();
        chk("R6 extra edge sdo", sdo, 1'b0);
        chk("R6 extra edge frame", frame, 1'b0);
        close_rd();

        // inverted framing
        frame_inv = 1'b1;
        load(18'h30F0F);
        @(negedge clk);
        chk("R4 idle high", frame, 1'b1);
        open_rd();
        read_bits(W, "R4 R5");
        chk("R4 frame back idle", frame, 1'b1);
        chk("R6 sdo idle inv", sdo, 1'b0);
        close_rd();
        frame_inv = 1'b0;

        // chip select high gates the clock
        load(18'h12345);
        cs_n = 1'b1; rd_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 cs high sdo", sdo, 1'b0);
        chk("R1 cs high frame", frame, 1'b0);
        repeat (3) sck_pulse();
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        read_bits(W, "R2 cs gated");
        close_rd();

        // read high: output disabled, no shift
        load(18'h3C3A5);
        cs_n = 1'b0; rd_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 rd high sdo", sdo, 1'b0);
        chk("R1 rd high frame", frame, 1'b0);
        repeat (2) sck_pulse();
        rd_n = 1'b0;
        repeat (2) @(negedge clk);
        read_bits(W, "R2 rd gated");
        close_rd();

        // partial read overwritten
        load(18'h2F00F);
        open_rd();
        read_bits(5, "R5 partial");
        load(18'h15A5A);
        chk("R7 err pulse", rd_err, 1'b1);
        @(negedge clk);
        chk("R7 err one cycle", rd_err, 1'b0);
        read_bits(W, "R7 restart MSB");
        load(18'h0FFF0);
        chk("R7 no err after full read", rd_err, 1'b0);
        load(18'h35555);
        chk("R7 no err before read start", rd_err, 1'b0);
        read_bits(W, "R5 after reload");
        close_rd();

        // load and shift edge in the same cycle
        load(18'h0A0A5);
        open_rd();
        read_bits(3, "R8 lead-in");
        sclk_ext = 1'b1;
        @(negedge clk);
        @(negedge clk);
        conv_data = 18'h3E1C7;
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        exp_q.delete();
        for (int i = W - 1; i >= 0; i--) exp_q.push_back(conv_data[i]);
        chk("R8 err on collision", rd_err, 1'b1);
        sclk_ext = 1'b0;
        repeat (4) @(negedge clk);
        read_bits(W, "R8 load wins");
        chk("R8 sdo idle", sdo, 1'b0);
        close_rd();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule